// File: doc/BRIEF.md
# Select-Gated Command/Address Register

This block is the registering stage on a memory-module command and address bus. On every rising clock edge it samples a 22-bit address/command word, the chip-select lines, and two clock-enable and two termination-control bits. One cycle later it presents them on its outputs. The address/command word goes out on two identical output ports, A and B, which feed two groups of memory devices. The word is only reloaded when a chip select is active in the capture cycle. Otherwise both ports keep their previous value, so the heavily loaded output nets do not toggle on idle cycles.

A static mode input chooses the chip-select arrangement. With the mode input high (a floating pin is modelled as high), only selects 0 and 1 are used. Each of them drives two output copies: output bit 0 and bit 2 carry select 0, and output bit 1 and bit 3 carry select 1. With the mode input low, all four selects are used and output bit i carries input bit i. The clock-enable and termination bits are registered every cycle whether or not any select is active.

The bus is sampled on every cycle and cannot be stalled, so the block has no valid/ready handshake and no back-pressure. A synchronous active-low reset loads all registers with their idle values. Chip selects are active low.

Top module: `cs_gated_cmd_reg`

## Requirements
- R1: On a rising edge with `rst_n` low, every select output becomes 1, both address ports become 0, and the clock-enable and termination outputs become 0.
- R2: With `pair_mode` high, `cs_out_n` after an edge equals {cs1, cs0, cs1, cs0} of the `cs_in_n` value sampled at that edge. Bits 0 and 1 are the A copies and bits 2 and 3 are the B copies.
- R3: With `pair_mode` low, `cs_out_n` after an edge equals the `cs_in_n` value sampled at that edge, bit for bit.
- R4: With `pair_mode` high, `cs_in_n[3:2]` have no effect on any output. A cycle with only those bits low leaves both address ports unchanged.
- R5: When a select used by the current mode is low at an edge, both address ports take the sampled `addr_in` value one cycle later.
- R6: When no select used by the current mode is low at an edge, both address ports hold their previous value.
- R7: `cke_out` and `odt_out` equal `cke_in` and `odt_in` sampled at the previous edge, regardless of the selects.
- R8: Ports `qa_addr` and `qb_addr` are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pair_mode | input | 1 | 1: two selects each duplicated; 0: four selects passed through one-to-one |
| cs_in_n | input | 4 | Chip select inputs, active low |
| addr_in | input | 22 | Address/command word |
| cke_in | input | 2 | Clock-enable inputs |
| odt_in | input | 2 | Termination-control inputs |
| cs_out_n | output | 4 | Registered chip selects |
| qa_addr | output | 22 | Address/command, port A |
| qb_addr | output | 22 | Address/command, port B |
| cke_out | output | 2 | Registered clock enables |
| odt_out | output | 2 | Registered termination controls |

## Verification
In pair mode the bench drives cycles where only selects 2 and 3 are low. A design that counted those lines would reload the address ports or pass the stray bits to the select outputs. Runs of fully idle cycles with changing address and control data check two things together: that the address ports hold, and that clock enable and termination keep following their inputs. A design that gated everything, or gated nothing, fails there. Reset is applied while a select is active, which catches a reset that loses priority to the load enable. Both modes are run with random data, which exposes swapped copy ordering or an extra cycle of latency.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  localparam int unsigned ADDR_BITS = 22;
  localparam int unsigned CS_LINES  = 4;
  localparam int unsigned CTRL_BITS = 2;
  localparam int unsigned OUT_PORTS = 2;

  typedef enum logic {
    MODE_QUAD = 1'b0,
    MODE_PAIR = 1'b1
  } cs_mode_e;
endpackage

// File: rtl/cs_route.sv
module cs_route #(
  parameter int unsigned N_CS = 4
) (
  input  logic            pair_mode,
  input  logic [N_CS-1:0] cs_in_n,
  output logic [N_CS-1:0] cs_next_n,
  output logic            any_sel
);
  import cmdreg_pkg::*;
  localparam int unsigned HALF = N_CS / 2;

  cs_mode_e mode;
  assign mode = cs_mode_e'(pair_mode);

  for (genvar i = 0; i < N_CS; i++) begin : g_line
    assign cs_next_n[i] = (mode == MODE_PAIR) ? cs_in_n[i % HALF] : cs_in_n[i];
  end

  always_comb begin
    if (mode == MODE_PAIR) any_sel = ~&cs_in_n[HALF-1:0];
    else                   any_sel = ~&cs_in_n;
  end
endmodule

// File: rtl/gated_reg.sv
module gated_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST_VAL;
    else if (en) q <= d;
  end
endmodule

// File: rtl/cs_gated_cmd_reg.sv
module cs_gated_cmd_reg #(
  parameter int unsigned ADDR_W = cmdreg_pkg::ADDR_BITS,
  parameter int unsigned N_CS   = cmdreg_pkg::CS_LINES,
  parameter int unsigned CTRL_W = cmdreg_pkg::CTRL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_mode,
  input  logic [N_CS-1:0]   cs_in_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [CTRL_W-1:0] cke_in,
  input  logic [CTRL_W-1:0] odt_in,
  output logic [N_CS-1:0]   cs_out_n,
  output logic [ADDR_W-1:0] qa_addr,
  output logic [ADDR_W-1:0] qb_addr,
  output logic [CTRL_W-1:0] cke_out,
  output logic [CTRL_W-1:0] odt_out
);
  localparam int unsigned NPORT = cmdreg_pkg::OUT_PORTS;

  logic [N_CS-1:0]   cs_next_n;
  logic              any_sel;
  logic [ADDR_W-1:0] port_q [NPORT];

  cs_route #(.N_CS(N_CS)) u_route (
    .pair_mode (pair_mode),
    .cs_in_n   (cs_in_n),
    .cs_next_n (cs_next_n),
    .any_sel   (any_sel)
  );

  gated_reg #(.W(N_CS), .RST_VAL({N_CS{1'b1}})) u_cs_q (
    .clk (clk), .rst_n (rst_n), .en (1'b1), .d (cs_next_n), .q (cs_out_n)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gated_reg #(.W(ADDR_W), .RST_VAL('0)) u_addr_q (
      .clk (clk), .rst_n (rst_n), .en (any_sel), .d (addr_in), .q (port_q[p])
    );
  end

  assign qa_addr = port_q[0];
  assign qb_addr = port_q[1];

  gated_reg #(.W(CTRL_W), .RST_VAL('0)) u_cke_q (
    .clk (clk), .rst_n (rst_n), .en (1'b1), .d (cke_in), .q (cke_out)
  );

  gated_reg #(.W(CTRL_W), .RST_VAL('0)) u_odt_q (
    .clk (clk), .rst_n (rst_n), .en (1'b1), .d (odt_in), .q (odt_out)
  );
endmodule

// File: rtl/cs_gated_cmd_reg_chk.sv
module cs_gated_cmd_reg_chk #(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned N_CS   = 4,
  parameter int unsigned CTRL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pair_mode,
  input logic [N_CS-1:0]   cs_in_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [CTRL_W-1:0] cke_in,
  input logic [CTRL_W-1:0] odt_in,
  input logic [N_CS-1:0]   cs_out_n,
  input logic [ADDR_W-1:0] qa_addr,
  input logic [ADDR_W-1:0] qb_addr,
  input logic [CTRL_W-1:0] cke_out,
  input logic [CTRL_W-1:0] odt_out
);
  localparam int unsigned HALF = N_CS / 2;

  logic used_low;
  assign used_low = pair_mode ? (cs_in_n[HALF-1:0] != {HALF{1'b1}}) : (cs_in_n != {N_CS{1'b1}});

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (cs_out_n == {N_CS{1'b1}} && qa_addr == '0 && qb_addr == '0 &&
                cke_out == '0 && odt_out == '0));

  assert_pair_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_mode |=> cs_out_n == {$past(cs_in_n[HALF-1:0]), $past(cs_in_n[HALF-1:0])});

  assert_quad_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_mode |=> cs_out_n == $past(cs_in_n));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    used_low |=> qa_addr == $past(addr_in));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !used_low |=> ($stable(qa_addr) && $stable(qb_addr)));

  assert_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cke_out == $past(cke_in) && odt_out == $past(odt_in)));

  assert_ports_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> qa_addr == qb_addr);
endmodule

bind cs_gated_cmd_reg cs_gated_cmd_reg_chk #(
  .ADDR_W (ADDR_W), .N_CS (N_CS), .CTRL_W (CTRL_W)
) u_chk (.*);

// File: tb/sim_cs_gated_cmd_reg.sv
`timescale 1ns/1ps
module sim_cs_gated_cmd_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pair_mode;
  logic [3:0]  cs_in_n;
  logic [21:0] addr_in;
  logic [1:0]  cke_in, odt_in;
  logic [3:0]  cs_out_n;
  logic [21:0] qa_addr, qb_addr;
  logic [1:0]  cke_out, odt_out;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          ended = 1'b0;

  logic [3:0]  e_cs;
  logic [21:0] e_addr;
  logic [1:0]  e_cke, e_odt;

  always #2 clk = ~clk;

  cs_gated_cmd_reg u0 (
    .clk (clk), .rst_n (rst_n), .pair_mode (pair_mode), .cs_in_n (cs_in_n),
    .addr_in (addr_in), .cke_in (cke_in), .odt_in (odt_in), .cs_out_n (cs_out_n),
    .qa_addr (qa_addr), .qb_addr (qb_addr), .cke_out (cke_out), .odt_out (odt_out)
  );

  function automatic logic [3:0] want_cs(input logic pm, input logic [3:0] cs);
    return pm ? {cs[1:0], cs[1:0]} : cs;
  endfunction

  function automatic logic want_load(input logic pm, input logic [3:0] cs);
    return pm ? (cs[1:0] != 2'b11) : (cs != 4'hF);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // drive at negedge, model the next edge, check after it
  task automatic step(input logic [3:0] cs, input logic [21:0] a,
                      input logic [1:0] k, input logic [1:0] o, input string addr_tag);
    logic ld;
    cs_in_n = cs; addr_in = a; cke_in = k; odt_in = o;
    ld = want_load(pair_mode, cs);
    if (!rst_n) begin
      e_cs = 4'hF; e_addr = '0; e_cke = '0; e_odt = '0;
    end else begin
      e_cs = want_cs(pair_mode, cs);
      if (ld) e_addr = a;
      e_cke = k; e_odt = o;
    end
    @(posedge clk);
    @(negedge clk);
    if (!rst_n) begin
      chk("R1", "cs_out_n", cs_out_n, 4'hF);
      chk("R1", "qa_addr", qa_addr, 0);
      chk("R1", "qb_addr", qb_addr, 0);
      chk("R1", "cke/odt", {cke_out, odt_out}, 0);
    end else begin
      chk(pair_mode ? "R2" : "R3", "cs_out_n", cs_out_n, e_cs);
      chk(addr_tag.len() != 0 ? addr_tag : (ld ? "R5" : "R6"), "qa_addr", qa_addr, e_addr);
      chk("R8", "qb_addr", qb_addr, qa_addr);
      chk("R7", "cke/odt", {cke_out, odt_out}, {e_cke, e_odt});
    end
  endtask

  task automatic rand_steps(input int n);
    for (int i = 0; i < n; i++) begin
      logic [3:0] cs;
      cs = ($urandom % 4 == 0) ? 4'hF : 4'($urandom);
      step(cs, 22'($urandom), 2'($urandom), 2'($urandom), "");
    end
  endtask

  initial begin
    #400us;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; pair_mode = 1'b1;
    cs_in_n = 4'hF; addr_in = '0; cke_in = '0; odt_in = '0;
    @(negedge clk);
    // R1: reset with an active select and data present
    step(4'h0, 22'h3FFFFF, 2'b11, 2'b11, "");
    step(4'h0, 22'h155555, 2'b10, 2'b01, "");
    rst_n = 1'b1;

    // pair mode
    step(4'b1110, 22'h0ABCDE, 2'b01, 2'b10, "R5");
    // R4: only the unused selects low -> no reload, no effect on cs outputs
    step(4'b0011, 22'h3C3C3C, 2'b10, 2'b01, "R4");
    step(4'b0111, 22'h2AAAAA, 2'b11, 2'b00, "R4");
    chk("R4", "cs_out_n", cs_out_n, 4'hF);
    // R6: idle run with changing data and control
    for (int i = 0; i < 4; i++) step(4'hF, 22'($urandom), 2'($urandom), 2'($urandom), "R6");
    step(4'b1101, 22'h012345, 2'b00, 2'b11, "R5");
    rand_steps(300);

    // quad mode, entered under reset
    rst_n = 1'b0;
    step(4'h0, 22'h1FFFFF, 2'b11, 2'b11, "");
    pair_mode = 1'b0;
    step(4'h0, 22'h1FFFFF, 2'b11, 2'b11, "");
    rst_n = 1'b1;
    step(4'b0111, 22'h0F0F0F, 2'b01, 2'b01, "R5");
    step(4'b1011, 22'h00FF00, 2'b10, 2'b10, "R5");
    step(4'b1111, 22'h3FFF00, 2'b11, 2'b00, "R6");
    step(4'b0101, 22'h123456, 2'b00, 2'b01, "R3");
    rand_steps(300);

    finish_run();
  end
endmodule